// File: doc/BRIEF.md
# Linear Frequency Sweep Engine

This block generates the tuning word that feeds a phase accumulator, one word per clock cycle. It holds a base tuning word and adds the signed output of a separate sweep accumulator. The base word never changes while a sweep runs. At a programmable interval, the sweep accumulator adds a signed delta word. This produces a linear frequency ramp that can run upward or downward. One delta LSB is worth two base-word LSBs.

A single load strobe captures all control words at the same time: base word, delta word, ramp rate and clear bit. Between loads, the input pins have no effect. The step interval is the ramp-rate word times eight clock cycles. A rate of zero stops the ramp, and nothing else stops it. Setting the clear bit drops the sweep contribution to zero, so the output returns at once to the base word.

Top module: `dds_sweep_engine`

## Requirements
- R1: After reset, `ftw_o` is 0 and `step_o` is 0.
- R2: `ftw_o` equals the loaded base word plus the sweep accumulator, modulo 2^FTW_W.
- R2: The base word changes only on a load.
- R3: Each step adds the delta word to the accumulator.
  - The delta word is read as DELTA_W-bit two's complement.
  - It is sign-extended to FTW_W bits and multiplied by 2.
  - The accumulator wraps modulo 2^FTW_W and never saturates.
- R4: With a nonzero rate word R loaded at clock edge k, steps occur at edges k+8R, k+16R, and so on.
  - `step_o` is high for the cycle that follows each stepping edge.
- R5: While the loaded rate word is zero, no step occurs and `ftw_o` holds its value.
- R6: A load with the clear bit set zeroes the accumulator at the load edge.
  - The accumulator stays zero while that clear setting is active.
  - Rate intervals still elapse and still pulse `step_o`.
- R7: Changes on `base_ftw_i`, `delta_i`, `rate_i` and `autoclr_i` without `load_i` change neither `ftw_o` nor the step timing.
- R8: A load restarts the step interval from the load edge.
  - A load with the clear bit low keeps the accumulator value.
  - No step is applied on a load edge.
- R9: A negative delta sweeps the output downward, wrapping through zero modulo 2^FTW_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Strobe that captures all control words |
| base_ftw_i | input | FTW_W | Base tuning word |
| delta_i | input | DELTA_W | Signed delta step word |
| rate_i | input | RATE_W | Step interval in units of 8 cycles; 0 stops the ramp |
| autoclr_i | input | 1 | Clear bit; holds the sweep accumulator at zero |
| ftw_o | output | FTW_W | Effective tuning word |
| step_o | output | 1 | Pulses for one cycle after each step edge |

## Verification
Several properties are checked on every cycle:
- A zero rate never produces a step.
- An active clear keeps the accumulator at zero.
- Each step adds exactly twice the sign-extended delta.
- The accumulator is frozen between steps.
- The base word moves only on a load.
- A checker counter confirms that every step falls exactly 8R cycles after the previous step or load.

Only the bench scenarios, compared against a cycle model, can show the rest:
- The absolute output values over long ramps.
- Wrap-around through zero and through the top of the range.
- Inputs changing without a load being ignored.
- A reload restarting the interval in mid-count.

// File: rtl/dds_sweep_pkg.sv
package dds_sweep_pkg;
    // log2 of the rate-word time unit, in clock cycles
    localparam int unsigned RATE_UNIT_LOG2 = 3;
    // left shift applied to the delta word relative to the base word LSB
    localparam int unsigned DELTA_SHIFT = 1;
endpackage

// File: rtl/sweep_rate_timer.sv
module sweep_rate_timer
    import dds_sweep_pkg::*;
#(
    parameter int unsigned RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              step_o,
    output logic [RATE_W-1:0] rate_o
);
    localparam int unsigned CNT_W = RATE_W + RATE_UNIT_LOG2;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [CNT_W-1:0]  cnt;
    } timer_state_t;

    timer_state_t r_d, r_q;
    logic         fire;

    function automatic logic [CNT_W-1:0] reload_value(input logic [RATE_W-1:0] r);
        return {r, {RATE_UNIT_LOG2{1'b0}}} - CNT_W'(1);
    endfunction

    always_comb begin
        r_d  = r_q;
        fire = (r_q.rate != '0) && (r_q.cnt == '0) && !load_i;
        if (load_i) begin
            r_d.rate = rate_i;
            r_d.cnt  = (rate_i == '0) ? '0 : reload_value(rate_i);
        end else if (fire) begin
            r_d.cnt = reload_value(r_q.rate);
        end else if (r_q.rate != '0) begin
            r_d.cnt = r_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign step_o = fire;
    assign rate_o = r_q.rate;
endmodule

// File: rtl/sweep_accum.sv
module sweep_accum
    import dds_sweep_pkg::*;
#(
    parameter int unsigned ACC_W   = 32,
    parameter int unsigned DELTA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [DELTA_W-1:0] delta_i,
    input  logic               clr_i,
    input  logic               step_i,
    output logic [ACC_W-1:0]   acc_o,
    output logic               clr_o,
    output logic [DELTA_W-1:0] delta_o
);
    localparam int unsigned EXT_W = ACC_W - DELTA_W;

    typedef struct packed {
        logic [DELTA_W-1:0] delta;
        logic               clr;
        logic [ACC_W-1:0]   acc;
    } accum_state_t;

    accum_state_t     r_d, r_q;
    logic [ACC_W-1:0] incr;

    always_comb begin
        r_d  = r_q;
        incr = {{EXT_W{r_q.delta[DELTA_W-1]}}, r_q.delta} << DELTA_SHIFT;
        if (load_i) begin
            r_d.delta = delta_i;
            r_d.clr   = clr_i;
            if (clr_i) begin
                r_d.acc = '0;
            end
        end else if (r_q.clr) begin
            r_d.acc = '0;
        end else if (step_i) begin
            r_d.acc = r_q.acc + incr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign acc_o   = r_q.acc;
    assign clr_o   = r_q.clr;
    assign delta_o = r_q.delta;
endmodule

// File: rtl/dds_sweep_engine.sv
module dds_sweep_engine #(
    parameter int unsigned FTW_W   = 32,
    parameter int unsigned DELTA_W = 16,
    parameter int unsigned RATE_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FTW_W-1:0]   base_ftw_i,
    input  logic [DELTA_W-1:0] delta_i,
    input  logic [RATE_W-1:0]  rate_i,
    input  logic               autoclr_i,
    output logic [FTW_W-1:0]   ftw_o,
    output logic               step_o
);
    typedef struct packed {
        logic [FTW_W-1:0] base;
        logic             step;
    } top_state_t;

    top_state_t         r_d, r_q;
    logic               step_w;
    logic [RATE_W-1:0]  rate_w;
    logic [FTW_W-1:0]   acc_w;
    logic               clr_w;
    logic [DELTA_W-1:0] delta_w;
    logic [FTW_W-1:0]   base_w;

    sweep_rate_timer #(
        .RATE_W (RATE_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .rate_i (rate_i),
        .step_o (step_w),
        .rate_o (rate_w)
    );

    sweep_accum #(
        .ACC_W   (FTW_W),
        .DELTA_W (DELTA_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .delta_i (delta_i),
        .clr_i   (autoclr_i),
        .step_i  (step_w),
        .acc_o   (acc_w),
        .clr_o   (clr_w),
        .delta_o (delta_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.step = step_w;
        if (load_i) begin
            r_d.base = base_ftw_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign base_w = r_q.base;
    assign ftw_o  = r_q.base + acc_w;
    assign step_o = r_q.step;
endmodule

// File: rtl/dds_sweep_checker.sv
module dds_sweep_checker #(
    parameter int unsigned FTW_W   = 32,
    parameter int unsigned DELTA_W = 16,
    parameter int unsigned RATE_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_i,
    input logic               step,
    input logic [RATE_W-1:0]  rate,
    input logic [FTW_W-1:0]   acc,
    input logic               clr,
    input logic [DELTA_W-1:0] delta,
    input logic [FTW_W-1:0]   base
);
    logic [FTW_W-1:0] add_amt;
    logic [31:0]      gap_q;
    logic [31:0]      interval;

    assign add_amt  = FTW_W'($signed(delta)) * FTW_W'(2);
    assign interval = {13'b0, rate, 3'b000};

    // cycles elapsed since the last load or step edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= 32'd1;
        end else if (load_i || step) begin
            gap_q <= 32'd1;
        end else begin
            gap_q <= gap_q + 32'd1;
        end
    end

    p_no_step_zero_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == '0) |-> !step);

    p_clear_holds_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (acc == '0));

    p_step_adds_delta_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (acc == $past(acc) + $past(add_amt)));

    p_idle_acc_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_i && !clr) |=> $stable(acc));

    p_base_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(base));

    p_step_on_interval_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (gap_q == interval));

    p_step_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rate != '0) && (gap_q == interval) && !load_i) |-> step);
endmodule

bind dds_sweep_engine dds_sweep_checker #(
    .FTW_W   (FTW_W),
    .DELTA_W (DELTA_W),
    .RATE_W  (RATE_W)
) u_sweep_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .step   (step_w),
    .rate   (rate_w),
    .acc    (acc_w),
    .clr    (clr_w),
    .delta  (delta_w),
    .base   (base_w)
);

// File: tb/test_dds_sweep_engine.sv
module test_dds_sweep_engine;
    localparam int unsigned FTW_W   = 32;
    localparam int unsigned DELTA_W = 16;
    localparam int unsigned RATE_W  = 16;
    localparam int          WD_CYC  = 150000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               load_i = 1'b0;
    logic [FTW_W-1:0]   base_ftw_i = '0;
    logic [DELTA_W-1:0] delta_i = '0;
    logic [RATE_W-1:0]  rate_i = '0;
    logic               autoclr_i = 1'b0;
    logic [FTW_W-1:0]   ftw_o;
    logic               step_o;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit finished = 0;

    typedef struct {
        logic [FTW_W-1:0] ftw;
        logic             stp;
        string            req;
    } exp_t;
    exp_t sb_q[$];

    // reference model state
    logic [FTW_W-1:0]   m_base = '0;
    logic [DELTA_W-1:0] m_delta = '0;
    int                 m_rate = 0;
    bit                 m_clr = 0;
    logic [FTW_W-1:0]   m_acc = '0;
    int                 m_el = 0;
    bit                 m_stp = 0;

    always #10 clk = ~clk;

    dds_sweep_engine #(
        .FTW_W   (FTW_W),
        .DELTA_W (DELTA_W),
        .RATE_W  (RATE_W)
    ) i_dds_sweep_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .base_ftw_i (base_ftw_i),
        .delta_i    (delta_i),
        .rate_i     (rate_i),
        .autoclr_i  (autoclr_i),
        .ftw_o      (ftw_o),
        .step_o     (step_o)
    );

    // driver side: the model predicts the outputs after each edge and queues them
    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = '0; m_delta = '0; m_rate = 0; m_clr = 0;
            m_acc = '0; m_el = 0; m_stp = 0;
        end else begin
            exp_t e;
            m_stp = 0;
            if (load_i) begin
                m_base  = base_ftw_i;
                m_delta = delta_i;
                m_rate  = int'(rate_i);
                m_clr   = autoclr_i;
                m_el    = 0;
                if (autoclr_i) m_acc = '0;
            end else if (m_rate != 0) begin
                m_el = m_el + 1;
                if (m_el == 8 * m_rate) begin
                    longint sd;
                    m_el  = 0;
                    m_stp = 1;
                    sd = longint'($signed(m_delta));
                    if (!m_clr) m_acc = m_acc + FTW_W'(sd * 2);
                end
            end
            e.ftw = m_base + m_acc;
            e.stp = m_stp;
            e.req = cur_req;
            sb_q.push_back(e);
        end
    end

    // monitor side
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (ftw_o !== e.ftw || step_o !== e.stp) begin
                fails++;
                $display("FAIL %s: ftw_o=%h step_o=%b expected ftw_o=%h step_o=%b",
                         e.req, ftw_o, step_o, e.ftw, e.stp);
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load_cfg(input logic [FTW_W-1:0] b, input logic [DELTA_W-1:0] d,
                            input logic [RATE_W-1:0] r, input logic c, input string req);
        @(negedge clk);
        cur_req    = req;
        base_ftw_i = b;
        delta_i    = d;
        rate_i     = r;
        autoclr_i  = c;
        load_i     = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic direct(input logic [FTW_W-1:0] act, input logic [FTW_W-1:0] exp_v,
                          input string req);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    initial begin
        // R1: reset state
        tick(3);
        direct(ftw_o, '0, "R1");
        direct({31'b0, step_o}, '0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        tick(5);
        direct(ftw_o, '0, "R1");

        // R2 R3 R4: upward ramp, rate 1 -> step every 8 cycles, +10 per step
        load_cfg(32'h1000_0000, 16'd5, 16'd1, 1'b0, "R4");
        tick(31);
        direct(ftw_o, 32'h1000_0000 + 32'd30, "R2");
        tick(10);

        // R7: inputs move without a load
        cur_req = "R7";
        base_ftw_i = 32'hDEAD_BEEF; delta_i = 16'h0100; rate_i = 16'd0; autoclr_i = 1'b1;
        tick(40);

        // R9: downward ramp wrapping below zero
        load_cfg(32'h0000_0000, 16'hFFFD, 16'd2, 1'b0, "R9");
        tick(400);

        // R6: clear returns to base at once and holds
        load_cfg(32'h0000_1234, 16'd7, 16'd1, 1'b1, "R6");
        direct(ftw_o, 32'h0000_1234, "R6");
        tick(40);

        // R5: zero rate holds the output
        load_cfg(32'h0000_0100, 16'd9, 16'd1, 1'b0, "R5");
        tick(20);
        load_cfg(32'h0000_0100, 16'd9, 16'd0, 1'b0, "R5");
        tick(60);

        // R8: reload in mid-interval restarts the count
        load_cfg(32'h0000_0100, 16'd3, 16'd3, 1'b0, "R8");
        tick(10);
        load_cfg(32'h0000_0200, 16'd3, 16'd3, 1'b0, "R8");
        tick(60);

        // R3: upward wrap past the top of the range
        load_cfg(32'hFFFF_FFF0, 16'h7FFF, 16'd1, 1'b1, "R3");
        load_cfg(32'hFFFF_FFF0, 16'h7FFF, 16'd1, 1'b0, "R3");
        tick(9);
        direct(ftw_o, 32'hFFFF_FFF0 + 32'h0000_FFFE, "R3");
        tick(30);

        tick(2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < WD_CYC; i++) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule